// File: doc/BRIEF.md
# Configurable Multi-Byte SPI Master

This block is a mode-selectable SPI master that moves one burst of full-duplex bytes between a local transmit buffer and a local receive buffer. The host writes transmit bytes into the buffer through a simple write port. It then presents a byte count, a 2-bit mode, an automatic chip-select flag and an 8-bit clock-slowdown factor, and pulses start. The master drives SCK, MOSI and an active-low chip select, samples MISO, and stores each received byte at the same index as the byte sent with it.

A burst runs through three phases: a setup gap, the shifting phase and a hold gap. SCK is placed at the mode's idle level before chip select falls, and it is back at that level before chip select rises. At the end the block pulses done, keeps the count of bytes moved, and raises an error flag when the request was malformed.

Top module: `spi_burst_master`

## Requirements
- R1: After reset SCK is 0, CS is 1, MOSI is 0, busy, done and error are 0, and the byte count output is 0.
- R2: In the mode field, bit 1 is CPOL and bit 0 is CPHA (0: CPOL0/CPHA0, 1: CPOL0/CPHA1, 2: CPOL1/CPHA0, 3: CPOL1/CPHA1). When a request is accepted, SCK goes to CPOL and rests there whenever no burst runs.
- R3: Bytes shift out MSB first. With CPHA=0, MISO is sampled on each edge that leaves the idle level, and the first MOSI bit is present before the first edge. With CPHA=1, MOSI changes on the leaving edge and MISO is sampled on the edge that returns to idle.
- R4: With the automatic chip select flag set, CS is low from the accept cycle until the done cycle, where it is high again. With the flag clear, CS stays high.
- R5: Whenever CS changes level, SCK is at the CPOL idle level.
- R6: With H = BASE_HALF + factor system clocks, the first SCK edge comes 2H clocks after the accept edge, each later edge follows H clocks after the previous one, and CS rises H clocks after the last edge.
- R7: A start with a count of 0 or above 50 sets the error flag and forces the count output to 0. SCK and CS do not change, and busy stays low. The next accepted start clears the error flag.
- R8: A start that arrives while a burst is busy, including the cycle in which CS is released, is ignored.
- R9: Done is high for exactly one cycle, in the cycle CS rises, and the count output then holds the burst length until the next start.
- R10: After a burst, reading receive index i returns the byte shifted in while transmit byte i was shifted out.
- R11: The count output increases by one on the trailing edge of each completed byte and never exceeds 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | SPI mode, bit 1 CPOL, bit 0 CPHA |
| auto_cs_i | input | 1 | Drive CS automatically during the burst |
| clk_factor_i | input | 8 | Half-period stretch in system clocks |
| num_bytes_i | input | 6 | Burst length, 1 to 50 |
| start_i | input | 1 | Start request, sampled while idle |
| tx_we_i | input | 1 | Transmit buffer write enable |
| tx_addr_i | input | 6 | Transmit buffer write index |
| tx_data_i | input | 8 | Transmit buffer write data |
| rx_addr_i | input | 6 | Receive buffer read index |
| rx_data_o | output | 8 | Receive buffer read data |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Active-low chip select |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| err_o | output | 1 | Last request had an invalid count |
| xfer_cnt_o | output | 6 | Bytes transferred |

## Verification
The release of chip select at the end of a burst and the acceptance of a new start request can land on neighbouring cycles. The bench holds start high across the last hold cycle and the done cycle. The model expects the request in the hold cycle to be dropped and the request in the done cycle to start a new burst, which leaves CS high for a single cycle. Every clock, the bench compares SCK, CS, MOSI, busy, done, error and count against a timeline that it computes from the cycles elapsed since acceptance.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD
  } spi_state_e;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       auto_cs;
    logic [7:0] factor;
  } spi_cfg_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int BASE_HALF = 2,
  parameter int FACTOR_W  = 8,
  localparam int HALF_W   = $clog2(BASE_HALF + (1 << FACTOR_W))
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [FACTOR_W-1:0] factor_i,
  output logic                tick_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;

  assign half   = HALF_W'(BASE_HALF) + HALF_W'(factor_i);
  assign tick_o = en_i && (cnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || tick_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  a_r6_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < half));
endmodule

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
  parameter int DEPTH = 50,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i && 32'(waddr_i) < DEPTH) mem[waddr_i] <= wdata_i;

  assign rdata_o = (32'(raddr_i) < DEPTH) ? mem[raddr_i] : '0;
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int MAX_BYTES = 50,
  parameter int BASE_HALF = 2,
  parameter int FACTOR_W  = 8,
  localparam int IDX_W    = $clog2(MAX_BYTES),
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                auto_cs_i,
  input  logic [FACTOR_W-1:0] clk_factor_i,
  input  logic [CNT_W-1:0]    num_bytes_i,
  input  logic                start_i,
  input  logic                tx_we_i,
  input  logic [IDX_W-1:0]    tx_addr_i,
  input  logic [7:0]          tx_data_i,
  input  logic [IDX_W-1:0]    rx_addr_i,
  output logic [7:0]          rx_data_o,
  output logic                sck_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic                cs_no,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [CNT_W-1:0]    xfer_cnt_o
);
  spi_state_e          state_q;
  logic                cpol_q, cpha_q;
  logic [FACTOR_W-1:0] factor_q;
  logic [CNT_W-1:0]    nbytes_q, byte_idx_q, cnt_q, nxt_idx;
  logic [2:0]          bit_q;
  logic [7:0]          tx_sr_q, rx_sr_q, tx_rdata, rx_byte;
  logic                sck_q, mosi_q, cs_nq, done_q, err_q;
  logic                tick, lead, byte_end, req_ok;
  logic [IDX_W-1:0]    tx_raddr;

  spi_half_timer #(.BASE_HALF(BASE_HALF), .FACTOR_W(FACTOR_W)) u_timer (
    .clk_i, .rst_ni,
    .en_i    (state_q != ST_IDLE),
    .factor_i(factor_q),
    .tick_o  (tick)
  );

  spi_byte_ram #(.DEPTH(MAX_BYTES), .DW(8)) u_tx_ram (
    .clk_i,
    .we_i   (tx_we_i),
    .waddr_i(tx_addr_i),
    .wdata_i(tx_data_i),
    .raddr_i(tx_raddr),
    .rdata_o(tx_rdata)
  );

  spi_byte_ram #(.DEPTH(MAX_BYTES), .DW(8)) u_rx_ram (
    .clk_i,
    .we_i   (byte_end),
    .waddr_i(byte_idx_q[IDX_W-1:0]),
    .wdata_i(rx_byte),
    .raddr_i(rx_addr_i),
    .rdata_o(rx_data_o)
  );

  assign nxt_idx  = byte_idx_q + 1'b1;
  assign tx_raddr = (state_q == ST_IDLE) ? '0 : nxt_idx[IDX_W-1:0];
  assign lead     = (sck_q == cpol_q);  // next edge leaves idle
  assign byte_end = (state_q == ST_XFER) && tick && !lead && (bit_q == 3'd7);
  assign rx_byte  = cpha_q ? {rx_sr_q[6:0], miso_i} : rx_sr_q;
  assign req_ok   = (num_bytes_i != '0) && (num_bytes_i <= CNT_W'(MAX_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      factor_q   <= '0;
      nbytes_q   <= '0;
      byte_idx_q <= '0;
      cnt_q      <= '0;
      bit_q      <= '0;
      tx_sr_q    <= '0;
      rx_sr_q    <= '0;
      sck_q      <= 1'b0;
      mosi_q     <= 1'b0;
      cs_nq      <= 1'b1;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (req_ok) begin
            cpol_q     <= mode_i[1];
            cpha_q     <= mode_i[0];
            factor_q   <= clk_factor_i;
            nbytes_q   <= num_bytes_i;
            byte_idx_q <= '0;
            cnt_q      <= '0;
            bit_q      <= '0;
            rx_sr_q    <= '0;
            err_q      <= 1'b0;
            sck_q      <= mode_i[1];
            cs_nq      <= !auto_cs_i;
            if (mode_i[0]) tx_sr_q <= tx_rdata;
            else begin
              mosi_q  <= tx_rdata[7];
              tx_sr_q <= {tx_rdata[6:0], 1'b0};
            end
            state_q <= ST_SETUP;
          end else begin
            err_q <= 1'b1;
            cnt_q <= '0;
          end
        end
        ST_SETUP: if (tick) state_q <= ST_XFER;
        ST_XFER: if (tick) begin
          sck_q <= ~sck_q;
          if (lead) begin
            if (!cpha_q) rx_sr_q <= {rx_sr_q[6:0], miso_i};
            else begin
              mosi_q  <= tx_sr_q[7];
              tx_sr_q <= {tx_sr_q[6:0], 1'b0};
            end
          end else begin
            if (cpha_q) rx_sr_q <= {rx_sr_q[6:0], miso_i};
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              byte_idx_q <= nxt_idx;
              cnt_q      <= cnt_q + 1'b1;
              if (nxt_idx == nbytes_q) state_q <= ST_HOLD;
              else if (cpha_q) tx_sr_q <= tx_rdata;
              else begin
                mosi_q  <= tx_rdata[7];
                tx_sr_q <= {tx_rdata[6:0], 1'b0};
              end
            end else if (!cpha_q) begin
              mosi_q  <= tx_sr_q[7];
              tx_sr_q <= {tx_sr_q[6:0], 1'b0};
            end
          end
        end
        ST_HOLD: if (tick) begin
          cs_nq   <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o      = sck_q;
  assign mosi_o     = mosi_q;
  assign cs_no      = cs_nq;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign xfer_cnt_o = cnt_q;

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r5_cs_fall_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_nq) |-> (sck_q == cpol_q));
  a_r5_cs_rise_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_nq) |-> (sck_q == cpol_q));
  a_r4_cs_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_nq |-> (state_q != ST_IDLE));
  a_r7_err_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (state_q == ST_IDLE));
  a_r6_sck_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_XFER && !tick) || state_q == ST_SETUP || state_q == ST_HOLD)
      |=> $stable(sck_q));
  a_r8_busy_keeps_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(nbytes_q));
  a_r11_cnt_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_BYTES));
endmodule

// File: tb/tb_spi_burst_master.sv
`timescale 1ns/1ps
module tb_spi_burst_master;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic       auto_cs_i = 1'b0;
  logic [7:0] clk_factor_i = '0;
  logic [5:0] num_bytes_i = '0;
  logic       start_i = 1'b0;
  logic       tx_we_i = 1'b0;
  logic [5:0] tx_addr_i = '0;
  logic [7:0] tx_data_i = '0;
  logic [5:0] rx_addr_i = '0;
  logic [7:0] rx_data_o;
  logic       sck_o, mosi_o, cs_no, busy_o, done_o, err_o;
  logic       miso_i = 1'b0;
  logic [5:0] xfer_cnt_o;

  spi_burst_master dut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] tx_ref [50];
  logic [7:0] slv    [50];

  // reference model state
  bit m_active = 0, m_err = 0, m_zero = 0, m_cpol = 0, m_cpha = 0, m_auto = 0;
  int m_c = 0, m_N = 1, m_H = 2, m_E = 0;
  bit chk_en = 0;
  bit prev_cs = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit sbit(int k);
    return slv[k/8][7-(k%8)];
  endfunction
  function automatic bit tbit(int k);
    return tx_ref[k/8][7-(k%8)];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_active = 0; m_c = 0; m_err = 0; m_zero = 0;
    end else begin
      bit busy_prev;
      busy_prev = m_active && (m_c < m_E);
      if (m_active && m_c <= m_E) m_c++;
      if (start_i && !busy_prev) begin
        if (num_bytes_i >= 1 && num_bytes_i <= 50) begin
          m_active = 1; m_c = 0; m_N = num_bytes_i; m_H = 2 + clk_factor_i;
          m_E = (16*m_N + 2) * m_H;
          m_cpol = mode_i[1]; m_cpha = mode_i[0]; m_auto = auto_cs_i;
          m_err = 0; m_zero = 0;
        end else begin
          m_err = 1; m_zero = 1;
        end
      end
    end
  end

  // per-cycle compare and slave drive
  always @(negedge clk_i) begin
    if (rst_ni && chk_en) begin
      int e, k;
      bit x_sck, x_cs, x_busy, x_done;
      int x_cnt;
      e = 0;
      if (m_active) begin
        if (m_c >= 2*m_H) e = m_c/m_H - 1;
        if (e > 16*m_N) e = 16*m_N;
      end
      x_sck  = m_active ? (m_cpol ^ e[0]) : 1'b0;
      x_cs   = (m_active && m_auto && m_c < m_E) ? 1'b0 : 1'b1;
      x_busy = m_active && (m_c < m_E);
      x_done = m_active && (m_c == m_E);
      x_cnt  = (m_zero || !m_active) ? 0 : e/16;
      chk(sck_o == x_sck, "R2/R6 sck", sck_o, x_sck);
      chk(cs_no == x_cs, "R4 cs", cs_no, x_cs);
      chk(busy_o == x_busy, "R8 busy", busy_o, x_busy);
      chk(done_o == x_done, "R9 done", done_o, x_done);
      chk(err_o == m_err, "R7 err", err_o, m_err);
      chk(int'(xfer_cnt_o) == x_cnt, "R11 count", xfer_cnt_o, x_cnt);
      if (cs_no != prev_cs)
        chk(sck_o == m_cpol, "R5 sck idle at cs change", sck_o, m_cpol);
      prev_cs = cs_no;
      if (m_active && m_c < m_E) begin
        if (!m_cpha && e < 16*m_N)
          chk(mosi_o == tbit(e/2), "R3 mosi cpha0", mosi_o, tbit(e/2));
        if (m_cpha && e >= 1)
          chk(mosi_o == tbit((e-1)/2), "R3 mosi cpha1", mosi_o, tbit((e-1)/2));
        k = m_cpha ? ((e >= 1) ? (e-1)/2 : 0) : (e+1)/2;
        miso_i = (k < 8*m_N) ? sbit(k) : 1'b0;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic load(input int n, input int seed);
    for (int i = 0; i < 50; i++) begin
      tx_ref[i] = 8'((i*53 + seed*11 + 3) & 255);
      slv[i]    = 8'((i*29 + seed*7 + 7) ^ 8'hA5);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tx_we_i = 1; tx_addr_i = 6'(i); tx_data_i = tx_ref[i];
    end
    @(negedge clk_i);
    tx_we_i = 0;
  endtask

  task automatic kick(input int mode, input bit acs, input int fac, input int n);
    @(negedge clk_i);
    mode_i = 2'(mode); auto_cs_i = acs; clk_factor_i = 8'(fac); num_bytes_i = 6'(n);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (m_active && m_c <= m_E);
  endtask

  task automatic readback(input int n);
    for (int i = 0; i < n; i++) begin
      rx_addr_i = 6'(i);
      #1;
      chk(rx_data_o == slv[i], "R10 rx byte", rx_data_o, slv[i]);
    end
    chk(int'(xfer_cnt_o) == n, "R9 count holds", xfer_cnt_o, n);
  endtask

  task automatic burst(input int mode, input bit acs, input int fac, input int n, input int seed);
    load(n, seed);
    kick(mode, acs, fac, n);
    wait_idle();
    readback(n);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values, sampled while reset is held
    chk(sck_o == 0 && cs_no == 1 && mosi_o == 0, "R1 reset pins", {sck_o, cs_no, mosi_o}, 3'b010);
    chk(busy_o == 0 && done_o == 0 && err_o == 0 && xfer_cnt_o == 0, "R1 reset status",
        {busy_o, done_o, err_o, xfer_cnt_o}, 0);
    rst_ni = 1;
    chk_en = 1;

    burst(0, 1, 0, 3, 1);    // R2 R3 mode 0
    burst(2, 1, 1, 2, 2);    // CPOL 1, CPHA 0
    burst(3, 0, 255, 1, 3);  // R4 manual CS, slowest rate

    // R8 start mid-burst ignored
    load(2, 4);
    kick(1, 1, 3, 2);
    repeat (100) @(negedge clk_i);
    num_bytes_i = 6'd5; mode_i = 2'd0; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    wait_idle();
    readback(2);

    // R7 invalid counts
    kick(0, 1, 0, 0);
    repeat (3) @(negedge clk_i);
    chk(err_o == 1 && cs_no == 1 && busy_o == 0, "R7 count zero", {err_o, cs_no, busy_o}, 3'b110);
    kick(2, 1, 0, 51);
    repeat (3) @(negedge clk_i);
    chk(err_o == 1 && xfer_cnt_o == 0, "R7 count 51", {err_o, xfer_cnt_o}, 7'b1000000);

    // R6 R11 longest burst, mode 3
    burst(3, 1, 0, 50, 5);

    // R8 R9 start held across the release cycle and the done cycle
    load(2, 6);
    kick(2, 1, 0, 1);
    do @(negedge clk_i); while (!(m_active && m_c == m_E - 1));
    num_bytes_i = 6'd2; mode_i = 2'd1; auto_cs_i = 1; clk_factor_i = 8'd0; start_i = 1;
    @(negedge clk_i);
    chk(done_o == 1 && cs_no == 1, "R9 release with start held", {done_o, cs_no}, 2'b11);
    @(negedge clk_i);
    start_i = 0;
    chk(busy_o == 1 && cs_no == 0, "R8 back-to-back accepted", {busy_o, cs_no}, 2'b10);
    wait_idle();
    readback(2);

    repeat (4) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule